// File: doc/BRIEF.md
# Receive checksum verification engine

This block sits in an Ethernet receive path and watches a byte-wide frame stream. It recognises IPv4 and IPv6 packets from the type field that follows the two MAC addresses. It checks the IPv4 header checksum and the TCP, UDP or ICMP checksum, and forwards every frame byte unchanged. After the last byte of each frame it adds four result bytes. The IPv4-header result comes first and the transport result follows. Each result is 16 bits and is sent most significant byte first.

A result of 0x0000 means the checksum was checked and found correct. 0xFFFF means nothing was checked. Any other value reports a mismatch. A 32-bit protocol-enable word decides which checks run. A separate enable input turns the whole engine on or off. The engine reports its real state on an activity output, which changes only between frames. Software clears the enable, waits for the activity output to fall, rewrites the protocol-enable word, and then sets the enable again.

Top module: `rx_csum_check`

## Requirements
- R1: Each input byte appears on the output one cycle later with `last_o` low. Two cycles after the input byte marked last, four result bytes follow in four consecutive cycles, and `last_o` is high on the fourth. A new frame must wait at least four idle cycles after the previous last byte.
- R2: The result bytes are ordered IPv4-header result MSB, then LSB, then transport result MSB, then LSB. A field whose checksum is checked and correct reads 0x0000.
- R3: A field whose checksum is checked and wrong reads the bitwise inverse of its 16-bit one's-complement sum. If that inverse would be 0xFFFF, the field reads 0xFFFE instead.
- R4: Both fields read 0xFFFF when any of these holds: the type field is neither 0x0800 (IPv4) nor 0x86DD (IPv6); the IPv4 version nibble is not 4; the IPv4 IHL is below 5; the IPv6 version nibble is not 6. For IPv6 packets the IPv4-header field always reads 0xFFFF.
- R5: A check runs only when its bit in `prot_en_i` is set; a disabled check reads 0xFFFF. Bit 0 enables the IPv4 header check. Bits 4, 5 and 6 enable TCP, UDP and ICMP over IPv4. Bits 20, 21 and 22 enable TCP, UDP and ICMPv6 over IPv6.
- R6: The transport protocol is taken from the IPv4 protocol byte or the IPv6 next-header byte. The recognised values are 6 (TCP), 17 (UDP), 1 (ICMP, IPv4 only) and 58 (ICMPv6, IPv6 only); any other value, including an IPv6 extension header, gives a transport field of 0xFFFF. The transport sum includes the pseudo-header (both addresses, the protocol value and the transport length) for every case except ICMP over IPv4.
- R7: For UDP over IPv4, a checksum field of zero in the datagram is reported as 0x0000.
- R8: The transport region runs from the end of the IP header to the end given by the IP length field, so padding after it is not summed. An odd final byte is summed as the high byte of a word whose low byte is zero.
- R9: If a frame ends before the end of the IPv4 header, the IPv4-header field reads 0xFFFF. If it ends before the end of the transport region, the transport field reads 0xFFFF.
- R10: `active_o` is 0 after reset. It follows `en_i` only when no frame is in progress, and a frame's result bytes count as part of that frame. A frame whose first byte arrives while `active_o` is 0 gets 0xFFFF in both fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable request |
| prot_en_i | input | 32 | Per-check enable word |
| active_o | output | 1 | Engine enable readback |
| valid_i | input | 1 | Input byte valid |
| last_i | input | 1 | Input byte is the last of its frame |
| data_i | input | 8 | Input byte |
| valid_o | output | 1 | Output byte valid |
| last_o | output | 1 | Output byte is the last result byte |
| data_o | output | 8 | Output byte |

## Verification
The bench uses the default counter width of 16 bits. With that width, an IP length field of any value can be compared against the byte position without wrapping. The frames stay under 100 bytes, so the counter never saturates. Every header offset, both IP versions, odd transport lengths, padding and truncated frames are all covered at that width.

// File: rtl/rx_csum_pkg.sv
package rx_csum_pkg;
  localparam int unsigned ETH_HDR = 14;
  localparam int unsigned V6_HDR  = 40;
  localparam logic [15:0] ET_V4 = 16'h0800;
  localparam logic [15:0] ET_V6 = 16'h86DD;
  localparam logic [7:0]  PR_ICMP4 = 8'd1;
  localparam logic [7:0]  PR_TCP   = 8'd6;
  localparam logic [7:0]  PR_UDP   = 8'd17;
  localparam logic [7:0]  PR_ICMP6 = 8'd58;
  localparam int unsigned EN_IP4H = 0;
  localparam int unsigned EN_TCP4 = 4;
  localparam int unsigned EN_UDP4 = 5;
  localparam int unsigned EN_ICM4 = 6;
  localparam int unsigned EN_TCP6 = 20;
  localparam int unsigned EN_UDP6 = 21;
  localparam int unsigned EN_ICM6 = 22;
  localparam logic [15:0] RES_SKIP = 16'hFFFF;

  typedef struct packed {
    logic        v4;
    logic        v6;
    logic        ver_ok;
    logic [5:0]  hlen;
    logic [15:0] len;
    logic [7:0]  proto;
    logic        ck_zero;
  } frm_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] oc_res(input logic [15:0] s);
    return (s == 16'h0000) ? 16'hFFFE : ~s;
  endfunction
endpackage

// File: rtl/rx_csum_accum.sv
module rx_csum_accum
  import rx_csum_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        add_i,
  input  logic        hi_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] sum_o
);
  logic [15:0] sum_q;
  logic [15:0] term;

  assign term  = hi_i ? {byte_i, 8'h00} : {8'h00, byte_i};
  assign sum_o = sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= oc_add(sum_q, term);
  end
endmodule

// File: rtl/rx_csum_parse.sv
module rx_csum_parse
  import rx_csum_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned EW   = CNT_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          last_i,
  input  logic [7:0]    data_i,
  output logic          clr_o,
  output logic          hi_o,
  output logic          ip_add_o,
  output logic          l4_add_o,
  output logic          ps_add_o,
  output frm_t          frm_o,
  output logic [EW-1:0] ip_end_o,
  output logic [EW-1:0] l4_end_o,
  output logic [EW-1:0] end_o
);
  logic [CNT_W-1:0] cnt_q, end_q;
  logic [7:0]       et_hi_q;
  frm_t             f_q;
  logic [EW-1:0]    idx, ip_end, l4_beg, l4_end;
  logic             ip_in, l4_in, ps_in;

  assign idx    = EW'(cnt_q);
  assign ip_end = EW'(ETH_HDR) + EW'(f_q.hlen);
  assign l4_beg = f_q.v4 ? ip_end : EW'(ETH_HDR + V6_HDR);
  assign l4_end = (f_q.v4 ? EW'(ETH_HDR) : EW'(ETH_HDR + V6_HDR)) + EW'(f_q.len);

  assign ip_in = f_q.v4 && idx >= EW'(ETH_HDR) && (idx == EW'(ETH_HDR) || idx < ip_end);
  assign l4_in = (f_q.v4 || f_q.v6) && f_q.ver_ok && idx >= l4_beg && idx < l4_end;
  assign ps_in = f_q.v4 ? (idx >= EW'(26) && idx <= EW'(33))
                        : (f_q.v6 && idx >= EW'(22) && idx <= EW'(53));

  assign clr_o    = valid_i && cnt_q == '0;
  assign hi_o     = ~cnt_q[0];
  assign ip_add_o = valid_i && ip_in;
  assign l4_add_o = valid_i && l4_in;
  assign ps_add_o = valid_i && ps_in;
  assign frm_o    = f_q;
  assign ip_end_o = ip_end;
  assign l4_end_o = l4_end;
  assign end_o    = EW'(end_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      end_q   <= '0;
      et_hi_q <= '0;
      f_q     <= '0;
    end else if (valid_i) begin
      cnt_q <= last_i ? '0 : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
      if (last_i) end_q <= cnt_q;
      if (cnt_q == '0) f_q <= '{ck_zero: 1'b1, default: '0};
      if (idx == EW'(12)) et_hi_q <= data_i;
      if (idx == EW'(13)) begin
        f_q.v4 <= {et_hi_q, data_i} == ET_V4;
        f_q.v6 <= {et_hi_q, data_i} == ET_V6;
      end
      if (idx == EW'(14)) begin
        f_q.ver_ok <= f_q.v4 ? (data_i[7:4] == 4'd4 && data_i[3:0] >= 4'd5)
                             : (data_i[7:4] == 4'd6);
        f_q.hlen   <= {data_i[3:0], 2'b00};
      end
      if ((f_q.v4 && idx == EW'(16)) || (f_q.v6 && idx == EW'(18))) f_q.len[15:8] <= data_i;
      if ((f_q.v4 && idx == EW'(17)) || (f_q.v6 && idx == EW'(19))) f_q.len[7:0]  <= data_i;
      if ((f_q.v4 && idx == EW'(23)) || (f_q.v6 && idx == EW'(20))) f_q.proto     <= data_i;
      if (l4_in && (idx == l4_beg + EW'(6) || idx == l4_beg + EW'(7)) && data_i != 8'h00)
        f_q.ck_zero <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_csum_check.sv
module rx_csum_check
  import rx_csum_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [31:0] prot_en_i,
  output logic        active_o,
  input  logic        valid_i,
  input  logic        last_i,
  input  logic [7:0]  data_i,
  output logic        valid_o,
  output logic        last_o,
  output logic [7:0]  data_o
);
  localparam int unsigned EW    = CNT_W + 1;
  localparam int unsigned TRL_N = 4;
  localparam int unsigned TC_W  = $clog2(TRL_N + 1);

  logic          clr, hi, ip_add, l4_add, ps_add;
  frm_t          f;
  logic [EW-1:0] ip_end, l4_end, end_idx;
  logic [15:0]   ip_sum, l4_sum, ps_sum;

  rx_csum_parse #(.CNT_W(CNT_W)) u_parse (
    .clk_i, .rst_ni, .valid_i, .last_i, .data_i,
    .clr_o(clr), .hi_o(hi), .ip_add_o(ip_add), .l4_add_o(l4_add), .ps_add_o(ps_add),
    .frm_o(f), .ip_end_o(ip_end), .l4_end_o(l4_end), .end_o(end_idx)
  );

  rx_csum_accum u_acc_ip (.clk_i, .rst_ni, .clr_i(clr), .add_i(ip_add), .hi_i(hi), .byte_i(data_i), .sum_o(ip_sum));
  rx_csum_accum u_acc_l4 (.clk_i, .rst_ni, .clr_i(clr), .add_i(l4_add), .hi_i(hi), .byte_i(data_i), .sum_o(l4_sum));
  rx_csum_accum u_acc_ps (.clk_i, .rst_ni, .clr_i(clr), .add_i(ps_add), .hi_i(hi), .byte_i(data_i), .sum_o(ps_sum));

  logic                  vq, lq, in_frame_q, chk_q, active_q;
  logic [7:0]            dq;
  logic [8*TRL_N-1:0]    trl_q;
  logic [TC_W-1:0]       trl_cnt_q;
  logic                  fin, idle;

  assign fin  = lq;
  assign idle = !in_frame_q && !vq && trl_cnt_q == '0 && !valid_i;

  // result computation, evaluated in the cycle after the last byte
  logic        l4_en, ip_ok, l4_ok, icmp4, udp4;
  logic [15:0] l4_len, ps_tot, l4_tot, ip_res, l4_res;
  logic        unused_cfg;

  assign unused_cfg = ^{prot_en_i[31:23], prot_en_i[19:7], prot_en_i[3:1]};

  always_comb begin
    l4_en = 1'b0;
    if (f.v4) begin
      case (f.proto)
        PR_TCP:   l4_en = prot_en_i[EN_TCP4];
        PR_UDP:   l4_en = prot_en_i[EN_UDP4];
        PR_ICMP4: l4_en = prot_en_i[EN_ICM4];
        default:  l4_en = 1'b0;
      endcase
    end else if (f.v6) begin
      case (f.proto)
        PR_TCP:   l4_en = prot_en_i[EN_TCP6];
        PR_UDP:   l4_en = prot_en_i[EN_UDP6];
        PR_ICMP6: l4_en = prot_en_i[EN_ICM6];
        default:  l4_en = 1'b0;
      endcase
    end
  end

  assign icmp4  = f.v4 && f.proto == PR_ICMP4;
  assign udp4   = f.v4 && f.proto == PR_UDP;
  assign l4_len = f.v4 ? f.len - {10'd0, f.hlen} : f.len;
  assign ps_tot = oc_add(oc_add(ps_sum, {8'd0, f.proto}), l4_len);
  assign l4_tot = icmp4 ? l4_sum : oc_add(l4_sum, ps_tot);

  assign ip_ok = chk_q && f.v4 && f.ver_ok && prot_en_i[EN_IP4H]
              && (end_idx + EW'(1)) >= ip_end;
  assign l4_ok = chk_q && (f.v4 || f.v6) && f.ver_ok && l4_en
              && (end_idx + EW'(1)) >= l4_end
              && !(f.v4 && f.len < {10'd0, f.hlen});

  assign ip_res = ip_ok ? oc_res(ip_sum) : RES_SKIP;
  assign l4_res = !l4_ok ? RES_SKIP : (udp4 && f.ck_zero) ? 16'h0000 : oc_res(l4_tot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vq         <= 1'b0;
      lq         <= 1'b0;
      dq         <= '0;
      in_frame_q <= 1'b0;
      chk_q      <= 1'b0;
      active_q   <= 1'b0;
      trl_q      <= '0;
      trl_cnt_q  <= '0;
    end else begin
      vq <= valid_i;
      lq <= valid_i && last_i;
      dq <= data_i;
      if (valid_i) in_frame_q <= !last_i;
      if (clr) chk_q <= active_q;
      if (idle) active_q <= en_i;
      if (fin) begin
        trl_q     <= {ip_res, l4_res};
        trl_cnt_q <= TC_W'(TRL_N);
      end else if (trl_cnt_q != '0) begin
        trl_q     <= trl_q << 8;
        trl_cnt_q <= trl_cnt_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign valid_o  = vq || trl_cnt_q != '0;
  assign last_o   = trl_cnt_q == TC_W'(1);
  assign data_o   = (trl_cnt_q != '0) ? trl_q[8*TRL_N-1 -: 8] : dq;
endmodule

// File: rtl/rx_csum_check_sva.sv
module rx_csum_check_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       active_o,
  input logic       valid_i,
  input logic       last_i,
  input logic [7:0] data_i,
  input logic       valid_o,
  input logic       last_o,
  input logic [7:0] data_o
);
  AST_PASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o && !last_o && data_o == $past(data_i)); // R1
  AST_TRAILER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |-> ##5 (valid_o && last_o)); // R1
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R1
  AST_EN_FALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(!en_i && !valid_i && !valid_o)); // R10
  AST_EN_RISE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(en_i && !valid_i && !valid_o)); // R10
endmodule

bind rx_csum_check rx_csum_check_sva u_sva (.*);

// File: tb/rx_csum_check_bench.sv
module rx_csum_check_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [31:0] prot_en_i = 32'h0070_0071;
  logic        active_o;
  logic        valid_i = 1'b0;
  logic        last_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        valid_o, last_o;
  logic [7:0]  data_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_csum_check u_rx_csum_check (.*);

  int nchk = 0;
  int nfail = 0;
  logic [7:0] fr [0:255];
  int fn, l4b, l4n;
  bit cur_v6;
  logic [7:0] cur_pr;
  logic [7:0] cap [0:299];
  bit capl [0:299];
  int capn = 0;

  always @(negedge clk_i)
    if (valid_o && capn < 300) begin
      cap[capn] = data_o;
      capl[capn] = last_o;
      capn++;
    end

  initial begin
    repeat (150000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rsum(int s, int len, logic [15:0] init);
    int unsigned acc = init;
    for (int i = 0; i < len; i += 2)
      acc += {fr[s+i], (i + 1 < len) ? fr[s+i+1] : 8'h00};
    while (acc >> 16) acc = (acc & 32'hFFFF) + (acc >> 16);
    return acc[15:0];
  endfunction

  function automatic logic [15:0] pseudo();
    int unsigned acc;
    acc = cur_v6 ? rsum(22, 32, 16'h0) : rsum(26, 8, 16'h0);
    acc += cur_pr;
    acc += l4n;
    while (acc >> 16) acc = (acc & 32'hFFFF) + (acc >> 16);
    return acc[15:0];
  endfunction

  function automatic logic [15:0] enc(logic [15:0] s);
    return (s == 16'h0000) ? 16'hFFFE : ~s;
  endfunction

  function automatic logic [15:0] exp_l4();
    return enc(rsum(l4b, l4n, (cur_v6 || cur_pr != 8'd1) ? pseudo() : 16'h0));
  endfunction

  function automatic logic [15:0] exp_ip();
    return enc(rsum(14, 20, 16'h0));
  endfunction

  task automatic mk_frame(bit v6, logic [7:0] pr, int len);
    int csoff;
    logic [15:0] s;
    cur_v6 = v6; cur_pr = pr; l4n = len;
    for (int i = 0; i < 12; i++) fr[i] = 8'h10 + 8'(i);
    {fr[12], fr[13]} = v6 ? 16'h86DD : 16'h0800;
    if (!v6) begin
      fr[14] = 8'h45; fr[15] = 8'h00; {fr[16], fr[17]} = 16'(20 + len);
      fr[18] = 8'h12; fr[19] = 8'h34; fr[20] = 8'h40; fr[21] = 8'h00;
      fr[22] = 8'h40; fr[23] = pr; fr[24] = 8'h00; fr[25] = 8'h00;
      {fr[26], fr[27], fr[28], fr[29]} = 32'hC0A8_010A;
      {fr[30], fr[31], fr[32], fr[33]} = 32'hC0A8_0114;
      {fr[24], fr[25]} = ~rsum(14, 20, 16'h0);
      l4b = 34;
    end else begin
      fr[14] = 8'h60; fr[15] = 8'h00; fr[16] = 8'h00; fr[17] = 8'h00;
      {fr[18], fr[19]} = 16'(len); fr[20] = pr; fr[21] = 8'h40;
      for (int i = 22; i < 54; i++) fr[i] = 8'h20 + 8'(i * 3);
      l4b = 54;
    end
    for (int i = 0; i < len; i++) fr[l4b+i] = 8'(i * 37 + 5);
    csoff = (pr == 8'd6) ? 16 : (pr == 8'd17) ? 6 : 2;
    if (pr == 8'd6 || pr == 8'd17 || (!v6 && pr == 8'd1) || (v6 && pr == 8'd58)) begin
      fr[l4b+csoff] = 8'h00; fr[l4b+csoff+1] = 8'h00;
      s = rsum(l4b, len, (v6 || pr != 8'd1) ? pseudo() : 16'h0);
      {fr[l4b+csoff], fr[l4b+csoff+1]} = ~s;
    end
    fn = l4b + len;
  endtask

  task automatic run(string rq, logic [15:0] e_ip, logic [15:0] e_l4, int drop_at);
    int bad = 0;
    int nl = 0;
    capn = 0;
    for (int i = 0; i < fn; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; data_i = fr[i]; last_i = (i == fn - 1);
      if (i == drop_at) en_i = 1'b0;
    end
    if (drop_at >= 0) chk(active_o == 1'b1, "R10", "active held mid-frame", 32'(active_o), 32'd1);
    @(negedge clk_i);
    valid_i = 1'b0; last_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk(capn == fn + 4, "R1", "output byte count", 32'(capn), 32'(fn + 4));
    for (int i = 0; i < fn; i++) if (cap[i] !== fr[i]) bad++;
    chk(bad == 0, "R1", "forwarded byte mismatches", 32'(bad), 32'd0);
    for (int i = 0; i < capn; i++) if (capl[i]) nl++;
    chk(nl == 1 && capl[fn+3], "R1", "last marker count", 32'(nl), 32'd1);
    chk({cap[fn], cap[fn+1]} == e_ip, rq, "ipv4 header field", {cap[fn], cap[fn+1]}, e_ip);
    chk({cap[fn+2], cap[fn+3]} == e_l4, rq, "transport field", {cap[fn+2], cap[fn+3]}, e_l4);
  endtask

  task automatic set_cfg(logic [31:0] v);
    en_i = 1'b0;
    while (active_o) @(negedge clk_i);
    prot_en_i = v;
    @(negedge clk_i);
    en_i = 1'b1;
    while (!active_o) @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1", "valid in reset", 32'(valid_o), 32'd0);
    chk(active_o == 1'b0, "R10", "active in reset", 32'(active_o), 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(active_o == 1'b1, "R10", "active after enable", 32'(active_o), 32'd1);
  endtask

  task automatic t_good_v4();
    mk_frame(0, 8'd6, 24);  run("R2", 16'h0000, 16'h0000, -1);
    mk_frame(0, 8'd17, 21); run("R6", 16'h0000, 16'h0000, -1);
    mk_frame(0, 8'd1, 8);   run("R6", 16'h0000, 16'h0000, -1);
  endtask

  task automatic t_bad_sums();
    logic [15:0] e;
    mk_frame(0, 8'd17, 21); fr[40] ^= 8'h5A; e = exp_l4();
    chk(e != 16'h0000 && e != 16'hFFFF, "R3", "bench transport value", 32'(e), 32'h1);
    run("R3", 16'h0000, e, -1);
    mk_frame(0, 8'd6, 24); fr[22] ^= 8'h01; e = exp_ip();
    run("R3", e, 16'h0000, -1);
  endtask

  task automatic t_udp_zero();
    mk_frame(0, 8'd17, 16); fr[40] = 8'h00; fr[41] = 8'h00;
    run("R7", 16'h0000, 16'h0000, -1);
  endtask

  task automatic t_v6();
    mk_frame(1, 8'd6, 20);  run("R4", 16'hFFFF, 16'h0000, -1);
    mk_frame(1, 8'd17, 9);  run("R6", 16'hFFFF, 16'h0000, -1);
    mk_frame(1, 8'd58, 8);  run("R6", 16'hFFFF, 16'h0000, -1);
    mk_frame(1, 8'd0, 16);  run("R6", 16'hFFFF, 16'hFFFF, -1);
  endtask

  task automatic t_unsupported();
    mk_frame(0, 8'd6, 20); fr[13] = 8'h06; run("R4", 16'hFFFF, 16'hFFFF, -1);
    mk_frame(0, 8'd6, 20); fr[14] = 8'h44; run("R4", 16'hFFFF, 16'hFFFF, -1);
  endtask

  task automatic t_enables();
    set_cfg(32'h0000_0001);
    mk_frame(0, 8'd6, 20); run("R5", 16'h0000, 16'hFFFF, -1);
    set_cfg(32'h0070_0070);
    mk_frame(0, 8'd6, 20); run("R5", 16'hFFFF, 16'h0000, -1);
    set_cfg(32'h0050_0071);
    mk_frame(1, 8'd17, 12); run("R5", 16'hFFFF, 16'hFFFF, -1);
    set_cfg(32'h0070_0071);
  endtask

  task automatic t_len_edges();
    mk_frame(0, 8'd17, 13);
    for (int i = 0; i < 6; i++) fr[fn+i] = 8'hEE;
    fn += 6;
    run("R8", 16'h0000, 16'h0000, -1);
    mk_frame(0, 8'd6, 30); fn -= 5;
    run("R9", 16'h0000, 16'hFFFF, -1);
    mk_frame(0, 8'd6, 30); fn = 30;
    run("R9", 16'hFFFF, 16'hFFFF, -1);
  endtask

  task automatic t_engine_off();
    en_i = 1'b0;
    while (active_o) @(negedge clk_i);
    mk_frame(0, 8'd6, 24); run("R10", 16'hFFFF, 16'hFFFF, -1);
    set_cfg(32'h0070_0071);
    mk_frame(0, 8'd6, 24); run("R10", 16'h0000, 16'h0000, 30);
    chk(active_o == 1'b0, "R10", "active after frame", 32'(active_o), 32'd0);
    set_cfg(32'h0070_0071);
  endtask

  initial begin
    t_reset();
    t_good_v4();
    t_bad_sums();
    t_udp_zero();
    t_v6();
    t_unsupported();
    t_enables();
    t_len_edges();
    t_engine_off();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule